// File: doc/BRIEF.md
# EDID Detailed Timing Selector

This block receives the 128-byte base block of a display's identification data one byte at a time. It scans the four 18-byte detailed-timing slots and keeps the one with the widest active line. When the block is complete, it converts that entry into absolute raster numbers: the pixel clock in kHz, and the display, sync start, sync end and total values for both axes. It also reports the sync polarities and the interlace flag.

The chosen mode is checked against a minimum of 640x480. A valid flag tells the display pipeline whether the native mode can be used. A digital-input flag is taken from the basic display parameters. The block does not verify the checksum and does not parse extension blocks or the short timing lists. The caller streams the bytes in with a qualifying strobe and may pause at any point.

Top module: `edid_timing_sel`

## Requirements
- R1: Byte positions are counted from reset, from 0 to 127, and the count wraps back to 0 after byte 127. A cycle with `inValid` low leaves the count unchanged, and its `inByte` value is ignored. Reset in the middle of a block restarts the count at 0.
- R2: Within a slot, bytes 0 and 1 hold the pixel clock, low byte first. A slot whose pixel clock is zero is skipped, however wide its other bytes claim it is.
- R3: A slot replaces the held choice only if its horizontal active size is strictly larger than the held one. The first of two equal widths is kept, and the vertical size plays no part in the choice.
- R4: Fields are unpacked from the slot bytes as follows. Horizontal active is byte4[7:4]:byte2 and horizontal blanking is byte4[3:0]:byte3. Vertical active is byte7[7:4]:byte5 and vertical blanking is byte7[3:0]:byte6. Horizontal sync offset is byte11[7:6]:byte8 and horizontal sync width is byte11[5:4]:byte9. Vertical sync offset is byte11[3:2]:byte10[7:4] and vertical sync width is byte11[1:0]:byte10[3:0]. For each axis, sync start = active + offset, sync end = sync start + width, and total = active + blanking.
- R5: `pixClkKhz` is the 16-bit clock field multiplied by 10.
- R6: `hSyncPos` = byte17[1] and `vSyncPos` = byte17[2`]` only when byte17[4:3] = 2'b11. For any other sync type, both are 0.
- R7: `interlaced` is a copy of byte17[7] of the chosen slot.
- R8: `outValid` is 0 in any of these cases: no slot was chosen, the vertical active size is 0, the horizontal active size is below 640, or the vertical active size is below 480.
- R9: `outDigital` is bit 7 of block byte 20. The other bits of that byte have no effect.
- R10: One clock edge after the edge that accepts byte 127, all results update and `outDone` pulses for one cycle. At all other times the results hold.
- R11: Reset clears all outputs to 0.
- R12: The slots start at block bytes 54, 72, 90 and 108, and the choice is cleared at byte 0 of each block. A block with no usable slot therefore reports zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Qualifies `inByte` |
| inByte | input | 8 | Next byte of the base block |
| outDone | output | 1 | One-cycle pulse when results update |
| outValid | output | 1 | Chosen mode is usable |
| outDigital | output | 1 | Display reports a digital input |
| pixClkKhz | output | 20 | Pixel clock in kHz |
| hDisp | output | 12 | Horizontal active pixels |
| hSyncStart | output | 13 | Horizontal sync start |
| hSyncEnd | output | 14 | Horizontal sync end |
| hTotal | output | 13 | Horizontal total |
| vDisp | output | 12 | Vertical active lines |
| vSyncStart | output | 13 | Vertical sync start |
| vSyncEnd | output | 14 | Vertical sync end |
| vTotal | output | 13 | Vertical total |
| hSyncPos | output | 1 | Positive horizontal sync |
| vSyncPos | output | 1 | Positive vertical sync |
| interlaced | output | 1 | Interlaced mode |

## Verification
Every result is due exactly one edge after the edge that accepts byte 127, and at that same edge `outDone` rises. The bench drives each byte on a falling edge. After the last byte it waits one full cycle and samples on the following falling edge. At that point it expects `outDone` high with all values settled. One cycle later it samples again and expects `outDone` low with the values unchanged. Inserted idle gaps only move the edge that accepts byte 127. The sampling is always counted from that edge, so the expected values stay the same.

// File: rtl/edid_sel_pkg.sv
package edid_sel_pkg;
  parameter int BYTE_W    = 8;
  parameter int ACT_W     = 12;
  parameter int PCLK_W    = 16;
  parameter int BLOCK_LEN = 128;
  parameter int DESC_LEN  = 18;
  parameter int DESC_NUM  = 4;
  parameter int DESC_BASE = 54;
  parameter int DIG_IDX   = 20;
  parameter int DIG_BIT   = 7;
  parameter int FIELD_BYTES = 12;   // bytes 0..11 of a slot carry the numeric fields
  parameter int FLAG_POS  = 17;     // last byte of a slot carries the flags

  localparam int IDX_W = $clog2(BLOCK_LEN);
  localparam int POS_W = $clog2(DESC_LEN);
  localparam int PIX_W = PCLK_W + 4;
  localparam int SS_W  = ACT_W + 1;
  localparam int SE_W  = ACT_W + 2;
  localparam int TOT_W = ACT_W + 1;

  typedef struct packed {
    logic [PIX_W-1:0] pixClk;
    logic [ACT_W-1:0] hDisp;
    logic [SS_W-1:0]  hSyncStart;
    logic [SE_W-1:0]  hSyncEnd;
    logic [TOT_W-1:0] hTotal;
    logic [ACT_W-1:0] vDisp;
    logic [SS_W-1:0]  vSyncStart;
    logic [SE_W-1:0]  vSyncEnd;
    logic [TOT_W-1:0] vTotal;
    logic             hPos;
    logic             vPos;
    logic             interlace;
  } timing_t;

  typedef struct packed {
    logic             capEn;
    logic [POS_W-1:0] pos;
    logic             clearBest;
    logic             digCap;
    logic             evalEn;
    logic             finEn;
  } strobe_t;
endpackage

// File: rtl/edid_sel_ctrl.sv
module edid_sel_ctrl
  import edid_sel_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  output strobe_t stb
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BLOCK_LEN - 1);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(DESC_LEN - 1);

  logic [IDX_W-1:0]    idx;
  logic [POS_W-1:0]    descPos;
  logic                evalPend;
  logic                finPend;
  logic [DESC_NUM-1:0] slotIn;
  logic [DESC_NUM-1:0] slotLast;

  for (genvar g = 0; g < DESC_NUM; g++) begin : g_slot
    localparam int FIRST = DESC_BASE + g * DESC_LEN;
    assign slotIn[g]   = (int'(idx) >= FIRST) && (int'(idx) < FIRST + DESC_LEN);
    assign slotLast[g] = (int'(idx) == FIRST + DESC_LEN - 1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx      <= '0;
      descPos  <= '0;
      evalPend <= 1'b0;
      finPend  <= 1'b0;
    end else begin
      evalPend <= inValid && (|slotLast);
      finPend  <= inValid && (idx == IDX_LAST);
      if (inValid) idx <= (idx == IDX_LAST) ? '0 : idx + 1'b1;
      if (inValid && (|slotIn)) descPos <= (descPos == POS_LAST) ? '0 : descPos + 1'b1;
    end
  end

  assign stb.capEn     = inValid && (|slotIn);
  assign stb.pos       = descPos;
  assign stb.clearBest = inValid && (idx == '0);
  assign stb.digCap    = inValid && (int'(idx) == DIG_IDX);
  assign stb.evalEn    = evalPend;
  assign stb.finEn     = finPend;

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(idx) && $stable(descPos));
  p_slot_align_r12: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (|slotLast)) |-> (descPos == POS_LAST));
  p_fin_after_last_r10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (idx == IDX_LAST)) |=> finPend);
  p_strobes_apart_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({evalPend, finPend}));
endmodule

// File: rtl/edid_sel_dp.sv
module edid_sel_dp
  import edid_sel_pkg::*;
#(
  parameter int MIN_H = 640,
  parameter int MIN_V = 480
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] inByte,
  input  strobe_t           stb,
  output timing_t           tOut,
  output logic              oValid,
  output logic              oDigital,
  output logic              oDone
);
  logic [BYTE_W-1:0] raw [FIELD_BYTES];
  logic [BYTE_W-1:0] flagByte;
  logic              digReg;
  timing_t           cand;
  timing_t           best;
  logic              take;

  logic [PCLK_W-1:0] cClk;
  logic [ACT_W-1:0]  hA, hB, vA, vB;
  logic [9:0]        hSO, hSW;
  logic [5:0]        vSO, vSW;
  logic              sepSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < FIELD_BYTES; i++) raw[i] <= '0;
      flagByte <= '0;
      digReg   <= 1'b0;
    end else begin
      if (stb.capEn && (int'(stb.pos) < FIELD_BYTES)) raw[stb.pos[3:0]] <= inByte;
      if (stb.capEn && (int'(stb.pos) == FLAG_POS)) flagByte <= inByte;
      if (stb.digCap) digReg <= inByte[DIG_BIT];
    end
  end

  always_comb begin
    cClk    = {raw[1], raw[0]};
    hA      = {raw[4][7:4], raw[2]};
    hB      = {raw[4][3:0], raw[3]};
    vA      = {raw[7][7:4], raw[5]};
    vB      = {raw[7][3:0], raw[6]};
    hSO     = {raw[11][7:6], raw[8]};
    hSW     = {raw[11][5:4], raw[9]};
    vSO     = {raw[11][3:2], raw[10][7:4]};
    vSW     = {raw[11][1:0], raw[10][3:0]};
    sepSync = (flagByte[4:3] == 2'b11);

    cand.pixClk     = PIX_W'(cClk) * PIX_W'(10);
    cand.hDisp      = hA;
    cand.hSyncStart = SS_W'(hA) + SS_W'(hSO);
    cand.hSyncEnd   = SE_W'(hA) + SE_W'(hSO) + SE_W'(hSW);
    cand.hTotal     = TOT_W'(hA) + TOT_W'(hB);
    cand.vDisp      = vA;
    cand.vSyncStart = SS_W'(vA) + SS_W'(vSO);
    cand.vSyncEnd   = SE_W'(vA) + SE_W'(vSO) + SE_W'(vSW);
    cand.vTotal     = TOT_W'(vA) + TOT_W'(vB);
    cand.hPos       = sepSync && flagByte[1];
    cand.vPos       = sepSync && flagByte[2];
    cand.interlace  = flagByte[7];
  end

  assign take = stb.evalEn && (cClk != '0) && (hA > best.hDisp);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      best     <= '0;
      tOut     <= '0;
      oValid   <= 1'b0;
      oDigital <= 1'b0;
      oDone    <= 1'b0;
    end else begin
      if (stb.clearBest) best <= '0;
      else if (take)     best <= cand;
      oDone <= stb.finEn;
      if (stb.finEn) begin
        tOut     <= best;
        oDigital <= digReg;
        oValid   <= (best.hDisp != '0) && (best.vDisp != '0) &&
                    (best.hDisp >= ACT_W'(MIN_H)) && (best.vDisp >= ACT_W'(MIN_V));
      end
    end
  end

  p_widest_grows_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.evalEn && !stb.clearBest) |=> (best.hDisp >= $past(best.hDisp)));
  p_zero_clock_skip_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.evalEn && !stb.clearBest && (cClk == '0)) |=> $stable(best));
  p_min_mode_r8: assert property (@(posedge clk) disable iff (!rstN)
    oValid |-> (tOut.hDisp >= ACT_W'(MIN_H)) && (tOut.vDisp >= ACT_W'(MIN_V)));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !stb.finEn |=> $stable(tOut) && $stable(oValid) && $stable(oDigital));
endmodule

// File: rtl/edid_timing_sel.sv
module edid_timing_sel
  import edid_sel_pkg::*;
#(
  parameter int MIN_H_ACT = 640,
  parameter int MIN_V_ACT = 480
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [BYTE_W-1:0] inByte,
  output logic              outDone,
  output logic              outValid,
  output logic              outDigital,
  output logic [PIX_W-1:0]  pixClkKhz,
  output logic [ACT_W-1:0]  hDisp,
  output logic [SS_W-1:0]   hSyncStart,
  output logic [SE_W-1:0]   hSyncEnd,
  output logic [TOT_W-1:0]  hTotal,
  output logic [ACT_W-1:0]  vDisp,
  output logic [SS_W-1:0]   vSyncStart,
  output logic [SE_W-1:0]   vSyncEnd,
  output logic [TOT_W-1:0]  vTotal,
  output logic              hSyncPos,
  output logic              vSyncPos,
  output logic              interlaced
);
  strobe_t stb;
  timing_t tOut;

  edid_sel_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .stb     (stb)
  );

  edid_sel_dp #(.MIN_H(MIN_H_ACT), .MIN_V(MIN_V_ACT)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inByte   (inByte),
    .stb      (stb),
    .tOut     (tOut),
    .oValid   (outValid),
    .oDigital (outDigital),
    .oDone    (outDone)
  );

  assign pixClkKhz  = tOut.pixClk;
  assign hDisp      = tOut.hDisp;
  assign hSyncStart = tOut.hSyncStart;
  assign hSyncEnd   = tOut.hSyncEnd;
  assign hTotal     = tOut.hTotal;
  assign vDisp      = tOut.vDisp;
  assign vSyncStart = tOut.vSyncStart;
  assign vSyncEnd   = tOut.vSyncEnd;
  assign vTotal     = tOut.vTotal;
  assign hSyncPos   = tOut.hPos;
  assign vSyncPos   = tOut.vPos;
  assign interlaced = tOut.interlace;
endmodule

// File: tb/edid_timing_sel_test.sv
module edid_timing_sel_test;
  typedef struct packed {
    logic [15:0] pclk;
    logic [11:0] hA;
    logic [11:0] hB;
    logic [9:0]  hSO;
    logic [9:0]  hSW;
    logic [11:0] vA;
    logic [11:0] vB;
    logic [5:0]  vSO;
    logic [5:0]  vSW;
    logic [7:0]  flg;
    logic        dig;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{16'd14850, 12'd1920, 12'd280,  10'd88,   10'd44,   12'd1080, 12'd45,   6'd4,  6'd5,  8'h1E, 1'b1},
    '{16'd2518,  12'd640,  12'd160,  10'd16,   10'd96,   12'd480,  12'd45,   6'd10, 6'd2,  8'h18, 1'b0},
    '{16'd6500,  12'd1024, 12'd320,  10'd24,   10'd136,  12'd768,  12'd38,   6'd3,  6'd6,  8'h06, 1'b1},
    '{16'd7425,  12'd1920, 12'd280,  10'd88,   10'd44,   12'd540,  12'd22,   6'd2,  6'd5,  8'h9E, 1'b0},
    '{16'd65535, 12'd4095, 12'd4095, 10'd1023, 10'd1023, 12'd4095, 12'd4095, 6'd63, 6'd63, 8'h1A, 1'b1},
    '{16'd4000,  12'd800,  12'd256,  10'd40,   10'd128,  12'd400,  12'd28,   6'd1,  6'd4,  8'h1C, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [7:0]  inByte = 8'h00;
  logic        outDone, outValid, outDigital, hSyncPos, vSyncPos, interlaced;
  logic [19:0] pixClkKhz;
  logic [11:0] hDisp, vDisp;
  logic [12:0] hSyncStart, hTotal, vSyncStart, vTotal;
  logic [13:0] hSyncEnd, vSyncEnd;

  int  nChk = 0;
  int  nFail = 0;
  bit  finished = 1'b0;
  logic [7:0] blk [128];
  vec_t a, b;
  logic [31:0] heldH;

  always #10 clk = ~clk;

  edid_timing_sel uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inByte(inByte),
    .outDone(outDone), .outValid(outValid), .outDigital(outDigital),
    .pixClkKhz(pixClkKhz), .hDisp(hDisp), .hSyncStart(hSyncStart),
    .hSyncEnd(hSyncEnd), .hTotal(hTotal), .vDisp(vDisp),
    .vSyncStart(vSyncStart), .vSyncEnd(vSyncEnd), .vTotal(vTotal),
    .hSyncPos(hSyncPos), .vSyncPos(vSyncPos), .interlaced(interlaced)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic clearBlk(input logic digital);
    for (int i = 0; i < 128; i++) blk[i] = 8'h00;
    blk[20] = digital ? 8'h80 : 8'h7F;
  endtask

  task automatic putDesc(input int slot, input vec_t v);
    int base;
    base = 54 + 18 * slot;
    blk[base]    = v.pclk[7:0];
    blk[base+1]  = v.pclk[15:8];
    blk[base+2]  = v.hA[7:0];
    blk[base+3]  = v.hB[7:0];
    blk[base+4]  = {v.hA[11:8], v.hB[11:8]};
    blk[base+5]  = v.vA[7:0];
    blk[base+6]  = v.vB[7:0];
    blk[base+7]  = {v.vA[11:8], v.vB[11:8]};
    blk[base+8]  = v.hSO[7:0];
    blk[base+9]  = v.hSW[7:0];
    blk[base+10] = {v.vSO[3:0], v.vSW[3:0]};
    blk[base+11] = {v.hSO[9:8], v.hSW[9:8], v.vSO[5:4], v.vSW[5:4]};
    for (int k = 12; k < 17; k++) blk[base+k] = 8'hA5;
    blk[base+17] = v.flg;
  endtask

  task automatic sendBytes(input int count, input int gap);
    for (int i = 0; i < count; i++) begin
      if (gap != 0 && (i % gap) == 1) begin
        @(negedge clk); inValid = 1'b0; inByte = 8'hFF;
        @(negedge clk); inValid = 1'b0;
      end
      @(negedge clk); inValid = 1'b1; inByte = blk[i];
    end
    @(negedge clk); inValid = 1'b0; inByte = 8'h00;
  endtask

  // after the full block: one more edge applies the result, sample on the next falling edge
  task automatic sendBlk(input int gap);
    sendBytes(128, gap);
    @(negedge clk);
  endtask

  task automatic chkTiming(input string tag, input vec_t v);
    logic expV;
    expV = (v.pclk != 0) && (v.hA >= 640) && (v.vA >= 480);
    chk("R10", {tag, " done"}, 32'(outDone), 32'd1);
    chk("R5",  {tag, " pixClk"}, 32'(pixClkKhz), 32'(v.pclk) * 32'd10);
    chk("R4",  {tag, " hDisp"}, 32'(hDisp), 32'(v.hA));
    chk("R4",  {tag, " hSyncStart"}, 32'(hSyncStart), 32'(v.hA) + 32'(v.hSO));
    chk("R4",  {tag, " hSyncEnd"}, 32'(hSyncEnd), 32'(v.hA) + 32'(v.hSO) + 32'(v.hSW));
    chk("R4",  {tag, " hTotal"}, 32'(hTotal), 32'(v.hA) + 32'(v.hB));
    chk("R4",  {tag, " vDisp"}, 32'(vDisp), 32'(v.vA));
    chk("R4",  {tag, " vSyncStart"}, 32'(vSyncStart), 32'(v.vA) + 32'(v.vSO));
    chk("R4",  {tag, " vSyncEnd"}, 32'(vSyncEnd), 32'(v.vA) + 32'(v.vSO) + 32'(v.vSW));
    chk("R4",  {tag, " vTotal"}, 32'(vTotal), 32'(v.vA) + 32'(v.vB));
    chk("R6",  {tag, " hSyncPos"}, 32'(hSyncPos), 32'((v.flg[4:3] == 2'b11) && v.flg[1]));
    chk("R6",  {tag, " vSyncPos"}, 32'(vSyncPos), 32'((v.flg[4:3] == 2'b11) && v.flg[2]));
    chk("R7",  {tag, " interlaced"}, 32'(interlaced), 32'(v.flg[7]));
    chk("R8",  {tag, " valid"}, 32'(outValid), 32'(expV));
    chk("R9",  {tag, " digital"}, 32'(outDigital), 32'(v.dig));
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11", "done", 32'(outDone), 0);
    chk("R11", "valid", 32'(outValid), 0);
    chk("R11", "hDisp", 32'(hDisp), 0);
    chk("R11", "pixClk", 32'(pixClkKhz), 0);

    // table of single-slot vectors, slot rotates
    for (int k = 0; k < NVEC; k++) begin
      clearBlk(VECS[k].dig);
      putDesc(k % 4, VECS[k]);
      sendBlk(0);
      chkTiming($sformatf("vec%0d", k), VECS[k]);
    end

    // R10 hold: one cycle later done drops, values stay
    heldH = 32'(hDisp);
    @(negedge clk);
    chk("R10", "done drops", 32'(outDone), 0);
    chk("R10", "hold hDisp", 32'(hDisp), heldH);

    // R3 widest wins, first of equal widths kept, vertical ignored
    clearBlk(1'b1);
    a = VECS[0]; a.hA = 12'd1280; a.vA = 12'd1024; putDesc(0, a);
    a = VECS[0]; putDesc(1, a);
    b = VECS[0]; b.hA = 12'd1600; b.vA = 12'd2000; putDesc(2, b);
    b = VECS[0]; b.vA = 12'd1200; b.flg = 8'h80; putDesc(3, b);
    sendBlk(0);
    chkTiming("R3 widest", a);

    // R2 zero pixel clock slot skipped even though wider
    clearBlk(1'b0);
    a = VECS[0]; a.pclk = 16'd0; a.hA = 12'd3000; putDesc(0, a);
    b = VECS[2]; b.dig = 1'b0; putDesc(1, b);
    sendBlk(0);
    chkTiming("R2 skip", b);

    // R12 empty block reports zeros, R8 invalid
    clearBlk(1'b0);
    sendBlk(0);
    chk("R12", "empty hDisp", 32'(hDisp), 0);
    chk("R8", "empty valid", 32'(outValid), 0);

    // R8 boundaries
    clearBlk(1'b1);
    a = VECS[1]; a.vA = 12'd479; putDesc(0, a);
    sendBlk(0);
    chk("R8", "640x479 valid", 32'(outValid), 0);
    clearBlk(1'b1);
    a = VECS[1]; a.hA = 12'd639; putDesc(3, a);
    sendBlk(0);
    chk("R8", "639x480 valid", 32'(outValid), 0);
    clearBlk(1'b1);
    a = VECS[0]; a.vA = 12'd0; putDesc(2, a);
    sendBlk(0);
    chk("R8", "zero height valid", 32'(outValid), 0);

    // R1 idle gaps with garbage bytes do not disturb the count
    clearBlk(VECS[0].dig);
    putDesc(2, VECS[0]);
    sendBlk(5);
    chkTiming("R1 gaps", VECS[0]);

    // R1 reset mid-block restarts the count
    clearBlk(VECS[3].dig);
    putDesc(1, VECS[3]);
    sendBytes(60, 0);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    chk("R11", "mid reset valid", 32'(outValid), 0);
    sendBlk(0);
    chkTiming("R1 restart", VECS[3]);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule